// File: doc/BRIEF.md
# FMCW Sweep Timing Sequencer

This block paces the repeated frequency sweeps of a continuous-wave radar front end. While enabled, it runs an active sweep interval for a programmed number of clock cycles, then an idle gap for another programmed number of cycles, and repeats. A level output marks the active interval and can trigger the synthesizer ramp. A one-cycle pulse marks the first cycle of each sweep.

A skip count thins out the sweeps that are handed to capture. After a captured sweep, that many sweeps pass without capture before the next captured one. A skip count of zero captures every sweep. A third count sets how long into each gap the power amplifier stays on before its off-control is raised. That control is dropped again when the next sweep begins.

All counts are raw clock cycles. New values are taken only at the start of a sweep, so a sweep already in progress, and the gap that follows it, finish on the old values. Lowering the enable stops everything at once.

Top module: `sweep_timer`

## Requirements
- R1: While reset is asserted and while enable is low after reset, all four outputs are low.
- R2: A sweep lasts exactly the number of cycles in the sweep length taken at its start. A length of 0 acts as 1.
- R3: Each sweep is followed by a gap of exactly the gap length taken at that sweep's start, with 0 acting as 1. The next sweep begins on the cycle after the gap ends.
- R4: `sweep_start` is high for exactly the first cycle of each sweep and at no other time.
- R5: The first sweep after enable is captured. After each captured sweep, the next `skip_sweeps` sweeps are not captured, and the sweep after them is captured. The skip value is read at the start of each captured sweep. `capture_en` is high for every cycle of a captured sweep and low otherwise.
- R6: `pa_off` is high in the gap cycles from index P onward, where the first gap cycle has index 0 and P is the PA-off count taken at the preceding sweep start. It is low during sweeps and low outside a gap. If P is at least the gap length, it stays low.
- R7: When enable is low, all outputs are low in that same cycle. The skip state is cleared, so the next enable starts again with a captured sweep.
- R8: Changing the length, gap, PA-off or skip inputs during a sweep or gap has no effect until the next sweep start.
- R9: When enable is high at a clock edge while the block is idle, the first sweep begins in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces idle |
| sweep_cycles | input | CNT_W | Sweep length in cycles |
| gap_cycles | input | CNT_W | Gap length in cycles |
| pa_off_cycles | input | CNT_W | Gap cycles before the PA-off control rises |
| skip_sweeps | input | SKIP_W | Sweeps skipped between captured sweeps |
| sweep_on | output | 1 | High during a sweep |
| sweep_start | output | 1 | One-cycle pulse on the first sweep cycle |
| capture_en | output | 1 | High during captured sweeps |
| pa_off | output | 1 | Power amplifier off-control |

## Verification
The bench builds the block with CNT_W set to 10 and SKIP_W set to 4. These narrow widths keep it cheap to reach a full-scale sweep of 1023 cycles and a full-scale skip count of 15, which is where the skip counter reloads from an all-ones value. Short random lengths, including 0 and 1, exercise back-to-back sweeps with one-cycle gaps. Random enable drops land in every phase and check that the state is cleared.

// File: rtl/sweep_timer.sv
module sweep_timer #(
  parameter int CNT_W  = 32,
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  sweep_cycles,
  input  logic [CNT_W-1:0]  gap_cycles,
  input  logic [CNT_W-1:0]  pa_off_cycles,
  input  logic [SKIP_W-1:0] skip_sweeps,
  output logic              sweep_on,
  output logic              sweep_start,
  output logic              capture_en,
  output logic              pa_off
);
  localparam int CW1 = CNT_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_SWEEP, S_GAP} state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt, len_q, gap_q, pa_q;
  logic [SKIP_W-1:0] skip_left;
  logic              cap_q;

  wire [CW1-1:0] cnt_next = {1'b0, cnt} + CW1'(1);
  wire last_sweep = cnt_next >= {1'b0, len_q};
  wire last_gap   = cnt_next >= {1'b0, gap_q};
  wire start_now  = en && (st == S_IDLE || (st == S_GAP && last_gap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      st        <= S_IDLE;
      cnt       <= '0;
      len_q     <= '0;
      gap_q     <= '0;
      pa_q      <= '0;
      skip_left <= '0;
      cap_q     <= 1'b0;
    end else if (start_now) begin
      st        <= S_SWEEP;
      cnt       <= '0;
      len_q     <= sweep_cycles;
      gap_q     <= gap_cycles;
      pa_q      <= pa_off_cycles;
      cap_q     <= (skip_left == '0);
      skip_left <= (skip_left == '0) ? skip_sweeps : skip_left - SKIP_W'(1);
    end else if (st == S_SWEEP && last_sweep) begin
      st  <= S_GAP;
      cnt <= '0;
    end else begin
      cnt <= cnt_next[CNT_W-1:0];
    end
  end

  assign sweep_on    = en && (st == S_SWEEP);
  assign sweep_start = sweep_on && (cnt == '0);
  assign capture_en  = sweep_on && cap_q;
  assign pa_off      = en && (st == S_GAP) && (cnt >= pa_q);
endmodule

// File: rtl/sweep_timer_chk.sv
module sweep_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic sweep_on,
  input logic sweep_start,
  input logic capture_en,
  input logic pa_off
);
  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(sweep_on || sweep_start || capture_en || pa_off)); // R7
  AST_START_INSIDE_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |-> sweep_on); // R4
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |=> !sweep_start); // R4
  AST_RISE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_on) |-> sweep_start); // R4
  AST_CAPTURE_INSIDE_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |-> sweep_on); // R5
  AST_CAPTURE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_on && !sweep_start) |-> $stable(capture_en)); // R5
  AST_PA_OFF_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pa_off |-> !sweep_on); // R6
endmodule

bind sweep_timer sweep_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sweep_on(sweep_on),
  .sweep_start(sweep_start), .capture_en(capture_en), .pa_off(pa_off)
);

// File: tb/sweep_timer_test.sv
module sweep_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] sweep_cycles = '0;
  logic [CW-1:0] gap_cycles = '0;
  logic [CW-1:0] pa_off_cycles = '0;
  logic [SW-1:0] skip_sweeps = '0;
  logic sweep_on, sweep_start, capture_en, pa_off;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sweep_timer #(.CNT_W(CW), .SKIP_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .sweep_cycles(sweep_cycles), .gap_cycles(gap_cycles),
    .pa_off_cycles(pa_off_cycles), .skip_sweeps(skip_sweeps),
    .sweep_on(sweep_on), .sweep_start(sweep_start),
    .capture_en(capture_en), .pa_off(pa_off)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model: 0 idle, 1 sweep, 2 gap
  int m_st = 0, m_cnt = 0, m_sk = 0, m_len = 0, m_gap = 0, m_pa = 0;
  bit m_cap = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      m_st = 0; m_cnt = 0; m_sk = 0; m_cap = 0;
      m_len = 0; m_gap = 0; m_pa = 0;
    end else if (m_st == 0 || (m_st == 2 && m_cnt + 1 >= m_gap)) begin
      m_st = 1; m_cnt = 0;
      m_len = int'(sweep_cycles); m_gap = int'(gap_cycles); m_pa = int'(pa_off_cycles);
      m_cap = (m_sk == 0);
      m_sk = (m_sk == 0) ? int'(skip_sweeps) : m_sk - 1;
    end else if (m_st == 1 && m_cnt + 1 >= m_len) begin
      m_st = 2; m_cnt = 0;
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  function automatic bit exp_on();    return en && m_st == 1; endfunction
  function automatic bit exp_start(); return exp_on() && m_cnt == 0; endfunction
  function automatic bit exp_cap();   return exp_on() && m_cap; endfunction
  function automatic bit exp_pa();    return en && m_st == 2 && m_cnt >= m_pa; endfunction

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, expv);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (!en) begin
        check("R7 sweep_on idle", sweep_on, 0);
        check("R7 pa_off idle", pa_off, 0);
      end else begin
        check("R2 R3 sweep_on", sweep_on, exp_on());
        check("R4 sweep_start", sweep_start, exp_start());
        check("R5 capture_en", capture_en, exp_cap());
        check("R6 pa_off", pa_off, exp_pa());
      end
    end
  end

  task automatic set_params(input int l, input int g, input int p, input int s);
    sweep_cycles = CW'(l); gap_cycles = CW'(g); pa_off_cycles = CW'(p); skip_sweeps = SW'(s);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    #3;
    check("R1 reset sweep_on", sweep_on, 0);
    check("R1 reset start", sweep_start, 0);
    check("R1 reset capture", capture_en, 0);
    check("R1 reset pa_off", pa_off, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 idle outputs", {sweep_on, sweep_start, capture_en, pa_off}, 0);

    // directed: start latency, lengths, parameter hold
    set_params(6, 2, 1, 0);
    en = 1'b1;
    @(negedge clk); #1;
    check("R9 first sweep starts", sweep_start, 1);
    sweep_cycles = CW'(2);
    gap_cycles = CW'(4);
    n = 0;
    while (sweep_on) begin n++; @(negedge clk); #1; end
    check("R8 length held during sweep", n, 6);
    n = 0;
    while (!sweep_on) begin n++; @(negedge clk); #1; end
    check("R3 gap length held", n, 2);
    n = 0;
    while (sweep_on) begin n++; @(negedge clk); #1; end
    check("R2 new length used", n, 2);
    n = 0;
    while (!sweep_on) begin n++; @(negedge clk); #1; end
    check("R3 new gap length", n, 4);

    // directed: zero lengths act as one
    set_params(0, 0, 0, 0);
    repeat (12) @(negedge clk);
    // directed: maximum skip and full-scale sweep
    set_params(3, 1, 0, 15);
    repeat (120) @(negedge clk);
    set_params(1023, 3, 1, 1);
    repeat (2200) @(negedge clk);
    en = 1'b0;
    @(negedge clk); #1;
    check("R7 capture cleared", capture_en, 0);
    set_params(2, 2, 1, 3);
    en = 1'b1;
    @(negedge clk); #1;
    check("R7 capture after re-enable", capture_en, 1);

    // random phase
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if ($urandom % 30 == 0)
        set_params(($urandom % 8 == 0) ? 1023 : int'($urandom % 9),
                   int'($urandom % 7), int'($urandom % 8), int'($urandom % 16));
      if ($urandom % 400 == 0) begin
        en = 1'b0;
        repeat (int'($urandom % 4) + 1) @(negedge clk);
        en = 1'b1;
      end
    end
    @(negedge clk); #2;
    finish_run();
  end
endmodule